// File: doc/BRIEF.md
# Bitslip Word-Aligning Deserializer

This block turns a single-data-rate serial bit stream into parallel words. A fast clock samples one serial bit per edge. A slow clock, phase-aligned with the fast clock at exactly one eighth of its rate, receives one complete word per cycle. Because the word boundary after reset is arbitrary, a downstream training controller can shift that boundary one bit at a time by pulsing a request input in the slow domain. It keeps pulsing until a known training word, a repeating 1001_0011 pattern, appears at the output.

The fast domain keeps a shift register and a phase counter. Once per slow period, at a fixed phase, it captures a window of `2*WORD_W-1` recent bits. The slow domain keeps a slip counter and picks one `WORD_W`-bit slice of that window. A request is registered first, then counted, then applied to the output register. This gives a fixed two-cycle latency from the captured request to the slipped word. A static parameter removes the slip feature entirely. Reset is asynchronous and active-low, and each clock domain releases it synchronously.

Top module: `slip_deser`

## Requirements
- R1: Every slow cycle `par_q` holds `WORD_W` consecutive serial bits. Bit 0 is the most recently received bit and bit `WORD_W-1` is the oldest. While no slip is taken, successive words are adjacent, non-overlapping stretches of the stream.
- R2: While `rst_n` is low, `par_q` reads zero, and this takes effect without waiting for a clock edge.
- R3: A request is accepted only if `slip_req` was low in the previous slow cycle. When `slip_req` is high in two or more consecutive slow cycles, only one slip results.
- R4: Each accepted slip moves the word window one bit toward more recent data. For a stream with period `WORD_W`, the new word is the old word rotated as `{q[WORD_W-2:0], q[WORD_W-1]}`.
- R5: A request captured at slow edge n changes `par_q` at edge n+2. The word loaded at edge n+1 still uses the old alignment, and the alignment never changes without an accepted request.
- R6: After `WORD_W` accepted slips the window returns to its original boundary. On the step from the most recent position back to the oldest, the window moves `WORD_W-1` bits toward older data.
- R7: With `SLIP_EN` = 0, `slip_req` has no effect, and the word boundary stays where it was after reset.
- R8: With the repeating serial pattern 1,0,0,1,0,0,1,1 (oldest first), the output can be slipped to `8'hC9`. One further slip then gives `8'h93`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Bit-rate clock, `WORD_W` times the slow clock, rising edges aligned |
| clk_slow | input | 1 | Word-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| ser_in | input | 1 | Serial data, sampled on each rising edge of `clk_fast` |
| slip_req | input | 1 | One-cycle request, in the slow domain, to move the word boundary by one bit |
| par_q | output | WORD_W | Parallel word; bit 0 is the newest serial bit |

## Verification
The bench builds two instances side by side on the same stimulus: the default 8-bit build with slipping enabled, and a copy with `SLIP_EN` = 0. A pseudo-random stream lets the bench recover the window position from each output word. This makes adjacency, the one-bit steps, the wrap back to the oldest position and the two-cycle latency visible bit for bit. The disabled copy shows whether request pulses leave its alignment untouched. A periodic training pattern then exercises the rotation rule and the example words.

// File: rtl/slip_deser_pkg.sv
package slip_deser_pkg;

  // Window tap feeding output bit `bit_pos` when the slip counter holds `slip`.
  // A larger slip value selects more recent serial bits.
  function automatic int unsigned tap_index(input int unsigned bit_pos,
                                            input int unsigned slip,
                                            input int unsigned word_w);
    return bit_pos + word_w - 1 - slip;
  endfunction

endpackage

// File: rtl/slip_deser_rst_sync.sv
module slip_deser_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign srst_n = stage_q[1];

endmodule

// File: rtl/slip_deser_fast_path.sv
module slip_deser_fast_path #(
  parameter int unsigned WORD_W = 8
) (
  input  logic                  clk_fast,
  input  logic                  rst_n,
  input  logic                  ser_in,
  output logic [2*WORD_W-2:0]   win_o
);

  localparam int unsigned PH_W = $clog2(WORD_W);
  localparam int unsigned SR_W = 2 * WORD_W - 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(WORD_W - 1);
  localparam logic [PH_W-1:0] PH_CAP  = '0;

  logic [SR_W-1:0] sr_q, sr_d;
  logic [SR_W-1:0] cap_q;
  logic [PH_W-1:0] ph_q, ph_d;
  logic            cap_en;

  // next state: newest bit enters at index 0
  always_comb begin
    sr_d   = {sr_q[SR_W-2:0], ser_in};
    ph_d   = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
    cap_en = (ph_q == PH_CAP);
  end

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      ph_q  <= '0;
      cap_q <= '0;
    end else begin
      sr_q <= sr_d;
      ph_q <= ph_d;
      if (cap_en) begin
        cap_q <= sr_d;
      end
    end
  end

  assign win_o = cap_q;

endmodule

// File: rtl/slip_deser_slip_ctrl.sv
module slip_deser_slip_ctrl #(
  parameter int unsigned WORD_W  = 8,
  parameter bit          SLIP_EN = 1'b1
) (
  input  logic                        clk_slow,
  input  logic                        rst_n,
  input  logic                        slip_req,
  output logic [$clog2(WORD_W)-1:0]   sel_o
);

  localparam int unsigned PH_W = $clog2(WORD_W);
  localparam logic [PH_W-1:0] CNT_LAST = PH_W'(WORD_W - 1);
  localparam logic EN_B = SLIP_EN;

  logic            req_prev_q;
  logic            pend_q, pend_d;
  logic [PH_W-1:0] cnt_q, cnt_d;

  // accept a request only after a low cycle; one cycle later bump the counter
  always_comb begin
    pend_d = EN_B & slip_req & ~req_prev_q;
    if (pend_q) begin
      cnt_d = (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk_slow or negedge rst_n) begin
    if (!rst_n) begin
      req_prev_q <= 1'b0;
      pend_q     <= 1'b0;
      cnt_q      <= '0;
    end else begin
      req_prev_q <= slip_req;
      pend_q     <= pend_d;
      cnt_q      <= cnt_d;
    end
  end

  assign sel_o = cnt_q;

  // R3: a high cycle right after a high cycle never becomes a slip
  p_spacing_r3: assert property (@(posedge clk_slow) disable iff (!rst_n)
    (slip_req && req_prev_q) |=> !pend_q);

  // R4: an accepted slip advances the counter by exactly one position
  p_step_r4: assert property (@(posedge clk_slow) disable iff (!rst_n)
    (pend_q && cnt_q != CNT_LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R6: after the last position the counter returns to the first
  p_wrap_r6: assert property (@(posedge clk_slow) disable iff (!rst_n)
    (pend_q && cnt_q == CNT_LAST) |=> (cnt_q == '0));

  // R5: without an accepted request the alignment holds
  p_hold_r5: assert property (@(posedge clk_slow) disable iff (!rst_n)
    !pend_q |=> $stable(cnt_q));

  if (!SLIP_EN) begin : g_no_slip
    // R7: the disabled variant keeps its reset alignment
    p_noslip_r7: assert property (@(posedge clk_slow) disable iff (!rst_n)
      slip_req |=> (cnt_q == '0));
  end

endmodule

// File: rtl/slip_deser_word_sel.sv
module slip_deser_word_sel #(
  parameter int unsigned WORD_W = 8
) (
  input  logic                        clk_slow,
  input  logic                        rst_n,
  input  logic [2*WORD_W-2:0]         win_i,
  input  logic [$clog2(WORD_W)-1:0]   sel_i,
  output logic [WORD_W-1:0]           word_o
);

  import slip_deser_pkg::*;

  localparam int unsigned PH_W = $clog2(WORD_W);

  logic [WORD_W-1:0] tap [WORD_W];
  logic [WORD_W-1:0] word_d;
  logic [WORD_W-1:0] word_q;

  // one AND-OR multiplexer per output bit
  for (genvar k = 0; k < WORD_W; k++) begin : g_bit
    for (genvar s = 0; s < WORD_W; s++) begin : g_tap
      assign tap[k][s] = (sel_i == PH_W'(s)) & win_i[tap_index(k, s, WORD_W)];
    end
    assign word_d[k] = |tap[k];
  end

  always_ff @(posedge clk_slow or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else begin
      word_q <= word_d;
    end
  end

  assign word_o = word_q;

endmodule

// File: rtl/slip_deser.sv
module slip_deser #(
  parameter int unsigned WORD_W  = 8,
  parameter bit          SLIP_EN = 1'b1
) (
  input  logic              clk_fast,
  input  logic              clk_slow,
  input  logic              rst_n,
  input  logic              ser_in,
  input  logic              slip_req,
  output logic [WORD_W-1:0] par_q
);

  localparam int unsigned PH_W  = $clog2(WORD_W);
  localparam int unsigned WIN_W = 2 * WORD_W - 1;

  logic             rst_fast_n;
  logic             rst_slow_n;
  logic [WIN_W-1:0] win;
  logic [PH_W-1:0]  sel;

  slip_deser_rst_sync u_rst_fast (
    .clk    (clk_fast),
    .arst_n (rst_n),
    .srst_n (rst_fast_n)
  );

  slip_deser_rst_sync u_rst_slow (
    .clk    (clk_slow),
    .arst_n (rst_n),
    .srst_n (rst_slow_n)
  );

  slip_deser_fast_path #(.WORD_W(WORD_W)) u_fast (
    .clk_fast (clk_fast),
    .rst_n    (rst_fast_n),
    .ser_in   (ser_in),
    .win_o    (win)
  );

  slip_deser_slip_ctrl #(.WORD_W(WORD_W), .SLIP_EN(SLIP_EN)) u_ctrl (
    .clk_slow (clk_slow),
    .rst_n    (rst_slow_n),
    .slip_req (slip_req),
    .sel_o    (sel)
  );

  slip_deser_word_sel #(.WORD_W(WORD_W)) u_sel (
    .clk_slow (clk_slow),
    .rst_n    (rst_slow_n),
    .win_i    (win),
    .sel_i    (sel),
    .word_o   (par_q)
  );

endmodule

// File: tb/slip_deser_tb.sv
`timescale 1ns/1ps
module slip_deser_tb;

  localparam logic [7:0] TRAIN = 8'b1001_0011;

  typedef struct packed {
    logic       slip;
    logic [2:0] off;
  } row_t;

  // stimulus: slip request driven after the row's sample; expected: window offset
  localparam row_t TAB [24] = '{
    '{1'b0, 3'd0}, '{1'b1, 3'd0}, '{1'b0, 3'd0}, '{1'b1, 3'd0},
    '{1'b1, 3'd1}, '{1'b0, 3'd1}, '{1'b1, 3'd2}, '{1'b0, 3'd2},
    '{1'b1, 3'd2}, '{1'b0, 3'd3}, '{1'b1, 3'd3}, '{1'b0, 3'd4},
    '{1'b1, 3'd4}, '{1'b0, 3'd5}, '{1'b1, 3'd5}, '{1'b0, 3'd6},
    '{1'b1, 3'd6}, '{1'b0, 3'd7}, '{1'b1, 3'd7}, '{1'b0, 3'd0},
    '{1'b0, 3'd0}, '{1'b0, 3'd1}, '{1'b0, 3'd1}, '{1'b0, 3'd1}
  };

  logic       clk_fast, clk_slow, rst_n, ser_in, slip_req;
  logic [7:0] q_main, q_fix;
  logic       hist [0:4095];
  int         idx;
  logic [15:0] lfsr;
  bit         periodic;
  bit         done;
  int         n_tests, n_fail;

  slip_deser u_dut (
    .clk_fast (clk_fast), .clk_slow (clk_slow), .rst_n (rst_n),
    .ser_in (ser_in), .slip_req (slip_req), .par_q (q_main)
  );

  slip_deser #(.SLIP_EN(1'b0)) u_dut_noslip (
    .clk_fast (clk_fast), .clk_slow (clk_slow), .rst_n (rst_n),
    .ser_in (ser_in), .slip_req (slip_req), .par_q (q_fix)
  );

  // 100 MHz bit clock, word clock eight times slower, rising edges aligned
  initial begin
    clk_fast = 1'b1;
    forever #5 clk_fast = ~clk_fast;
  end
  initial begin
    clk_slow = 1'b0;
    forever #40 clk_slow = ~clk_slow;
  end

  // serial source, changes away from the sampling edge
  always @(negedge clk_fast) begin
    logic b;
    if (periodic) begin
      b = TRAIN[7 - (idx % 8)];
    end else begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      b = lfsr[0];
    end
    ser_in = b;
    if (idx < 4096) hist[idx] = b;
    idx = idx + 1;
  end

  function automatic logic [7:0] hwin(input int e);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) begin
      r[k] = (e - k >= 0 && e - k < 4096) ? hist[e - k] : 1'b0;
    end
    return r;
  endfunction

  task automatic tick();
    @(negedge clk_slow);
    #1;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pulse_and_wait();
    slip_req = 1'b1;
    tick();
    slip_req = 1'b0;
    tick();
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk_fast);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] wm [3];
    logic [7:0] wf [3];
    int         ix [3];
    int         lag_m, lag_f;
    logic [7:0] prev, fix0;
    bit         found;

    n_tests = 0; n_fail = 0; done = 1'b0;
    idx = 0; lfsr = 16'hACE1; periodic = 1'b0;
    ser_in = 1'b0; slip_req = 1'b0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;

    // R2: reset state
    repeat (3) tick();
    chk("R2 reset main", q_main, 8'h00);
    chk("R2 reset noslip", q_fix, 8'h00);
    rst_n = 1'b1;
    repeat (6) tick();

    // recover the window position from three adjacent words
    for (int j = 0; j < 3; j++) begin
      tick();
      wm[j] = q_main; wf[j] = q_fix; ix[j] = idx;
    end
    lag_m = -1; lag_f = -1;
    for (int l = 0; l <= 40; l++) begin
      bit okm, okf;
      okm = 1'b1; okf = 1'b1;
      for (int j = 0; j < 3; j++) begin
        if (hwin(ix[j] - l) !== wm[j]) okm = 1'b0;
        if (hwin(ix[j] - l) !== wf[j]) okf = 1'b0;
      end
      if (okm && lag_m < 0) lag_m = l;
      if (okf && lag_f < 0) lag_f = l;
    end
    n_tests++;
    if (lag_m < 0 || lag_f < 0) begin
      n_fail++;
      $display("FAIL R1 contiguous words: actual lag %0d/%0d expected a fixed lag", lag_m, lag_f);
      lag_m = 0; lag_f = 0;
    end

    // R1 R3 R4 R5 R6 R7: table walk on a pseudo-random stream
    for (int i = 0; i < 24; i++) begin
      tick();
      chk($sformatf("R1/R3/R4/R5/R6 row %0d", i), q_main,
          hwin(idx - (lag_m - int'(TAB[i].off))));
      chk($sformatf("R7 row %0d", i), q_fix, hwin(idx - lag_f));
      slip_req = TAB[i].slip;
    end
    slip_req = 1'b0;

    // training pattern
    periodic = 1'b1;
    repeat (5) tick();
    fix0 = q_fix;
    found = 1'b0;
    for (int t = 0; t < 8; t++) begin
      if (!found) begin
        if (q_main == 8'hC9) begin
          found = 1'b1;
        end else begin
          prev = q_main;
          slip_req = 1'b1;
          tick();
          slip_req = 1'b0;
          tick();
          chk("R5 old word one cycle after capture", q_main, prev);
          tick();
          chk("R4 rotate by one", q_main, {prev[6:0], prev[7]});
          chk("R7 noslip steady", q_fix, fix0);
        end
      end
    end
    chk("R8 reach C9", q_main, 8'hC9);
    pulse_and_wait();
    chk("R8 C9 slips to 93", q_main, 8'h93);

    // R3: two consecutive high cycles give one slip
    prev = q_main;
    slip_req = 1'b1;
    tick();
    tick();
    slip_req = 1'b0;
    tick();
    tick();
    chk("R3 back-to-back ignored", q_main, {prev[6:0], prev[7]});
    tick();
    chk("R3 no late extra slip", q_main, {prev[6:0], prev[7]});

    // R6: eight slips come back to the starting word
    prev = q_main;
    repeat (8) pulse_and_wait();
    chk("R6 eight slips wrap", q_main, prev);
    chk("R7 noslip after many pulses", q_fix, fix0);

    // R2: asynchronous reset mid-cycle
    #20 rst_n = 1'b0;
    #1;
    chk("R2 async clear main", q_main, 8'h00);
    chk("R2 async clear noslip", q_fix, 8'h00);
    rst_n = 1'b1;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule